// File: doc/BRIEF.md
# Triggered Scan Sequencer

This block paces an acquisition front end. It counts ticks of a shared timebase and issues a one-cycle scan-start strobe every programmed interval. A trigger mode sets which strobes belong to a run. The four modes cover capture after a trigger, capture before a trigger, a window around a trigger, and capture after a programmed delay. The delay can be counted in timebase ticks or in scan intervals. The trigger-after modes can optionally re-arm for a counted number of blocks.

Each strobe comes with a store flag that tells the downstream sample buffer whether to write that scan. A busy level covers the whole run. A one-cycle done pulse marks normal completion. A software stop or a reset drops the sequencer back to idle at once and clears every count.

Top module: `scan_seq_top`

## Requirements
- R1: During reset and after its release, `scan_start`, `store_en`, `done` and `acq_busy` are all low.
- R2: While scanning, the first strobe comes on the first timebase tick after the phase begins. After that, strobes are exactly `cfg_si` ticks apart. A `cfg_si` of 0 acts as 1.
- R3: With `cfg_mode`=0, the block issues no strobes before a trigger. After the trigger it issues exactly `cfg_psc` strobes, each with `store_en`. The strobe after the trigger edge comes one cycle later. `done` pulses once, together with the last strobe, and `acq_busy` then falls.
- R4: With `cfg_mode`=1, strobes start from the software start and the run ends at an accepted trigger. If the trigger is sampled on the same edge as a strobe, that strobe is still issued. No post-trigger strobes follow.
- R5: When `cfg_m_en` is high, a trigger sampled before `cfg_mcnt` pre-trigger strobes have been issued is ignored, and the run continues. When `cfg_m_en` is low, any trigger is accepted.
- R6: If `conv_busy` is high when a pre-trigger run accepts its trigger, the block stays busy with no further strobes and no `done`. `done` follows on the first cycle in which `conv_busy` is low.
- R7: With `cfg_mode`=2, the pre-trigger strobes run until an accepted trigger, and then exactly `cfg_psc` more strobes follow.
- R8: With `cfg_mode`=3, a trigger loads `cfg_dly`, which counts down to zero before `cfg_psc` strobes run. When `cfg_dly_src`=0 the count steps on timebase ticks, and with a steady tick the first strobe comes `cfg_dly`+2 cycles after the trigger edge. When `cfg_dly_src`=1 the count steps on scan intervals, and the first strobe comes (`cfg_dly`-1)·`cfg_si`+3 cycles after the trigger edge, or 2 cycles when `cfg_dly` is 0.
- R9: With `cfg_retrig_en` high in mode 0 or 3, each trigger starts a new block, up to `cfg_retrig_num` blocks, and a value of 0 counts as 1. Triggers during a running block or delay are ignored. `done` pulses once, after the last block.
- R10: A `sw_stop` drops `acq_busy` on the next edge with no `done` and no further strobes. A following run behaves as if from reset.
- R11: While `tb_tick` is low, no strobe is issued and the interval count holds.
- R12: `store_en` is only ever high together with `scan_start`. It is low for pre-trigger strobes when `cfg_mcnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_tick | input | 1 | Timebase clock enable |
| sw_start | input | 1 | Software start, accepted in idle only |
| sw_stop | input | 1 | Software abort to idle |
| trig | input | 1 | Trigger pulse, sampled each cycle |
| conv_busy | input | 1 | Conversion in progress |
| cfg_mode | input | 2 | 0 after, 1 before, 2 around, 3 delayed |
| cfg_si | input | SI_W | Scan interval in timebase ticks |
| cfg_psc | input | CNT_W | Strobes after the trigger per block |
| cfg_mcnt | input | CNT_W | Pre-trigger window length |
| cfg_m_en | input | 1 | Ignore triggers until the window has filled |
| cfg_dly | input | DLY_W | Delay count after the trigger |
| cfg_dly_src | input | 1 | Delay step: 0 timebase tick, 1 scan interval |
| cfg_retrig_en | input | 1 | Re-arm after each block |
| cfg_retrig_num | input | RT_W | Number of blocks when re-arming |
| scan_start | output | 1 | One-cycle scan strobe |
| store_en | output | 1 | Write this scan to the buffer |
| acq_busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at normal completion |

## Verification
A wrong interval count shows up at once as uneven strobe spacing, which the bench measures scan by scan within each block. A wrong post-trigger or block count shows up at the end of the run as a strobe total off by at least one. It can also appear as a `done` that comes early, late or twice. A window fill count or a delay count that is off moves the first accepted trigger or the first strobe by whole intervals or cycles. These are caught by an exact latency and count comparison. Counters left over from an aborted run would distort the very next run's totals.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [1:0] {
    TM_AFTER  = 2'd0,
    TM_BEFORE = 2'd1,
    TM_AROUND = 2'd2,
    TM_DELAY  = 2'd3
  } trig_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_PRE   = 3'd2,
    ST_DELAY = 3'd3,
    ST_POST  = 3'd4,
    ST_DRAIN = 3'd5
  } seq_state_e;

endpackage

// File: rtl/scan_seq_interval.sv
module scan_seq_interval #(
  parameter int SI_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic [SI_W-1:0] period_i,
  output logic            fire_o
);

  localparam logic [SI_W-1:0] ONE = SI_W'(1);

  logic [SI_W-1:0] cnt_q, cnt_d, reload;

  assign reload = (period_i == '0) ? '0 : period_i - ONE;
  assign fire_o = run_i && tick_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || restart_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = (cnt_q == '0) ? reload : cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R11
  tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i && !restart_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/scan_seq_delay.sv
module scan_seq_delay #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             load_i,
  input  logic [DLY_W-1:0] load_val_i,
  input  logic             step_i,
  output logic             zero_o
);

  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q, cnt_d;

  assign zero_o = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (!active_i) begin
      cnt_d = '0;
    end else if (step_i && (cnt_q != '0)) begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R8
  dly_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && !load_i) |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_seq_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int RT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_start_i,
  input  logic             sw_stop_i,
  input  logic             trig_i,
  input  logic             conv_busy_i,
  input  logic             fire_i,
  input  logic             dly_zero_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] psc_i,
  input  logic [CNT_W-1:0] mcnt_i,
  input  logic             m_en_i,
  input  logic             retrig_en_i,
  input  logic [RT_W-1:0]  retrig_num_i,
  output logic             run_o,
  output logic             restart_o,
  output logic             dly_active_o,
  output logic             dly_load_o,
  output logic             scan_o,
  output logic             store_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int BLK_W = RT_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [RT_W-1:0]  RT_ONE  = RT_W'(1);

  trig_mode_e mode;
  seq_state_e st_q, st_d;
  logic [CNT_W-1:0] psc_q, psc_d, fill_q, fill_d;
  logic [RT_W-1:0]  blk_q, blk_d, rlim;
  logic             scan_q, scan_d, store_q, store_d, done_q, done_d;
  logic             blk_end, fin, more, early;

  assign mode  = trig_mode_e'(mode_i);
  assign rlim  = !retrig_en_i ? RT_ONE :
                 (retrig_num_i == '0) ? RT_ONE : retrig_num_i;
  assign more  = ({1'b0, blk_q} + BLK_W'(1)) < {1'b0, rlim};
  assign early = m_en_i && (fill_q < mcnt_i);

  always_comb begin
    st_d       = st_q;
    psc_d      = psc_q;
    fill_d     = fill_q;
    blk_d      = blk_q;
    scan_d     = 1'b0;
    store_d    = 1'b0;
    done_d     = 1'b0;
    dly_load_o = 1'b0;
    blk_end    = 1'b0;
    fin        = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (sw_start_i) begin
          psc_d  = '0;
          fill_d = '0;
          blk_d  = '0;
          st_d   = (mode == TM_BEFORE || mode == TM_AROUND) ? ST_PRE : ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (trig_i) begin
          if (mode == TM_DELAY) begin
            st_d       = ST_DELAY;
            dly_load_o = 1'b1;
          end else if (psc_i == '0) begin
            blk_end = 1'b1;
          end else begin
            st_d  = ST_POST;
            psc_d = psc_i;
          end
        end
      end
      ST_PRE: begin
        if (fire_i) begin
          scan_d  = 1'b1;
          store_d = (mcnt_i != '0);
          if (fill_q < mcnt_i) fill_d = fill_q + CNT_ONE;
        end
        if (trig_i && !early) begin
          if (mode == TM_AROUND) begin
            if (psc_i == '0) begin
              fin = 1'b1;
            end else begin
              st_d  = ST_POST;
              psc_d = psc_i;
            end
          end else if (conv_busy_i) begin
            st_d = ST_DRAIN;
          end else begin
            fin = 1'b1;
          end
        end
      end
      ST_DELAY: begin
        if (dly_zero_i) begin
          if (psc_i == '0) begin
            blk_end = 1'b1;
          end else begin
            st_d  = ST_POST;
            psc_d = psc_i;
          end
        end
      end
      ST_POST: begin
        if (fire_i) begin
          scan_d  = 1'b1;
          store_d = 1'b1;
          psc_d   = psc_q - CNT_ONE;
          if (psc_q == CNT_ONE) blk_end = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!conv_busy_i) fin = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase

    if (blk_end) begin
      if (more) begin
        st_d  = ST_ARMED;
        blk_d = blk_q + RT_ONE;
      end else begin
        fin = 1'b1;
      end
    end
    if (fin) begin
      st_d   = ST_IDLE;
      done_d = 1'b1;
      psc_d  = '0;
      fill_d = '0;
      blk_d  = '0;
    end
    if (sw_stop_i) begin
      st_d       = ST_IDLE;
      psc_d      = '0;
      fill_d     = '0;
      blk_d      = '0;
      scan_d     = 1'b0;
      store_d    = 1'b0;
      done_d     = 1'b0;
      dly_load_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      psc_q   <= '0;
      fill_q  <= '0;
      blk_q   <= '0;
      scan_q  <= 1'b0;
      store_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      psc_q   <= psc_d;
      fill_q  <= fill_d;
      blk_q   <= blk_d;
      scan_q  <= scan_d;
      store_q <= store_d;
      done_q  <= done_d;
    end
  end

  assign run_o        = (st_q == ST_PRE) || (st_q == ST_DELAY) || (st_q == ST_POST);
  assign restart_o    = (st_d != st_q);
  assign dly_active_o = (st_q == ST_DELAY);
  assign scan_o       = scan_q;
  assign store_o      = store_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_o);

  // R5
  early_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE && early && !sw_stop_i) |=> (st_q == ST_PRE));

  // R6
  drain_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DRAIN) |=> !scan_q);

  // R9
  blk_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> ({1'b0, blk_q} < {1'b0, rlim}));

  // R10
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop_i |=> (!busy_o && !scan_q && !done_q));

  // R12
  store_with_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |-> scan_q);

endmodule

// File: rtl/scan_seq_top.sv
module scan_seq_top #(
  parameter int SI_W  = 24,
  parameter int CNT_W = 16,
  parameter int DLY_W = 16,
  parameter int RT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tb_tick,
  input  logic             sw_start,
  input  logic             sw_stop,
  input  logic             trig,
  input  logic             conv_busy,
  input  logic [1:0]       cfg_mode,
  input  logic [SI_W-1:0]  cfg_si,
  input  logic [CNT_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_mcnt,
  input  logic             cfg_m_en,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_dly_src,
  input  logic             cfg_retrig_en,
  input  logic [RT_W-1:0]  cfg_retrig_num,
  output logic             scan_start,
  output logic             store_en,
  output logic             acq_busy,
  output logic             done
);

  logic [1:0] rsync_q;
  logic       rst_n_s;
  logic       fire, run, restart, dly_active, dly_load, dly_zero, dly_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  assign dly_step = cfg_dly_src ? fire : tb_tick;

  scan_seq_interval #(.SI_W(SI_W)) u_interval (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick_i    (tb_tick),
    .run_i     (run),
    .restart_i (restart),
    .period_i  (cfg_si),
    .fire_o    (fire)
  );

  scan_seq_delay #(.DLY_W(DLY_W)) u_delay (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .active_i   (dly_active),
    .load_i     (dly_load),
    .load_val_i (cfg_dly),
    .step_i     (dly_step),
    .zero_o     (dly_zero)
  );

  scan_seq_ctrl #(.CNT_W(CNT_W), .RT_W(RT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .sw_start_i   (sw_start),
    .sw_stop_i    (sw_stop),
    .trig_i       (trig),
    .conv_busy_i  (conv_busy),
    .fire_i       (fire),
    .dly_zero_i   (dly_zero),
    .mode_i       (cfg_mode),
    .psc_i        (cfg_psc),
    .mcnt_i       (cfg_mcnt),
    .m_en_i       (cfg_m_en),
    .retrig_en_i  (cfg_retrig_en),
    .retrig_num_i (cfg_retrig_num),
    .run_o        (run),
    .restart_o    (restart),
    .dly_active_o (dly_active),
    .dly_load_o   (dly_load),
    .scan_o       (scan_start),
    .store_o      (store_en),
    .busy_o       (acq_busy),
    .done_o       (done)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_s |=> (!scan_start && !done));

endmodule

// File: tb/sim_scan_seq_top.sv
`timescale 1ns/1ps
module sim_scan_seq_top;
  localparam int SI_W = 24, CNT_W = 16, DLY_W = 16, RT_W = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, tb_tick, sw_start, sw_stop, trig, conv_busy;
  logic [1:0] cfg_mode;
  logic [SI_W-1:0] cfg_si;
  logic [CNT_W-1:0] cfg_psc, cfg_mcnt;
  logic cfg_m_en, cfg_dly_src, cfg_retrig_en;
  logic [DLY_W-1:0] cfg_dly;
  logic [RT_W-1:0] cfg_retrig_num;
  logic scan_start, store_en, acq_busy, done;

  scan_seq_top #(.SI_W(SI_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .RT_W(RT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick), .sw_start(sw_start), .sw_stop(sw_stop),
    .trig(trig), .conv_busy(conv_busy), .cfg_mode(cfg_mode), .cfg_si(cfg_si),
    .cfg_psc(cfg_psc), .cfg_mcnt(cfg_mcnt), .cfg_m_en(cfg_m_en), .cfg_dly(cfg_dly),
    .cfg_dly_src(cfg_dly_src), .cfg_retrig_en(cfg_retrig_en), .cfg_retrig_num(cfg_retrig_num),
    .scan_start(scan_start), .store_en(store_en), .acq_busy(acq_busy), .done(done));

  int checks = 0, errors = 0;
  int n_scan = 0, n_store = 0, n_done = 0, n_gapok = 0, cyc = 0, last_sc = -1000, exp_gap = 1;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (scan_start) begin
      n_scan = n_scan + 1;
      if (cyc - last_sc == exp_gap) n_gapok = n_gapok + 1;
      last_sc = cyc;
    end
    if (store_en) n_store = n_store + 1;
    if (done) n_done = n_done + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nfires(input int t, input int s);
    return (t >= 1) ? (t - 1) / s + 1 : 0;
  endfunction

  task automatic setup(input int mode, input int si, input int psc, input int mcnt,
                       input bit men, input int dly, input bit dsrc, input bit ren, input int rnum);
    cfg_mode = 2'(mode); cfg_si = SI_W'(si); cfg_psc = CNT_W'(psc); cfg_mcnt = CNT_W'(mcnt);
    cfg_m_en = men; cfg_dly = DLY_W'(dly); cfg_dly_src = dsrc; cfg_retrig_en = ren;
    cfg_retrig_num = RT_W'(rnum); exp_gap = (si == 0) ? 1 : si;
  endtask

  task automatic pulse_start();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
  endtask

  task automatic trig_at(input int t);
    repeat (t - 1) @(negedge clk);
    trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin @(negedge clk); w++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_post(input int s, input int p);
    int s0, t0, d0, g0;
    setup(0, s, p, 0, 0, 0, 0, 0, 1);
    s0 = n_scan; t0 = n_store; d0 = n_done; g0 = n_gapok;
    pulse_start();
    repeat (3) @(negedge clk);
    chk("R3 no scan before trigger", n_scan - s0, 0);
    trig_at(1);
    wait_done();
    chk("R3 post scans", n_scan - s0, p);
    chk("R3 post stores", n_store - t0, p);
    chk("R3 done once", n_done - d0, 1);
    chk("R2 interval spacing", n_gapok - g0, (p > 0) ? p - 1 : 0);
    chk("R3 idle after done", int'(acq_busy), 0);
  endtask

  task automatic run_pre(input int mode, input int s, input int m, input bit men, input int psc,
                         input int t1, input int t2, input int exp_sc, input int exp_st);
    int s0, t0, d0;
    setup(mode, s, psc, m, men, 0, 0, 0, 1);
    s0 = n_scan; t0 = n_store; d0 = n_done;
    pulse_start();
    trig_at(t1);
    if (t2 > 0) begin
      chk("R5 early trigger ignored", int'(acq_busy), 1);
      trig_at(t2 - t1);
    end
    wait_done();
    chk("R4 R7 scans", n_scan - s0, exp_sc);
    chk("R12 stores", n_store - t0, exp_st);
    chk("R4 done once", n_done - d0, 1);
  endtask

  task automatic run_retrig(input int mode, input bit ren, input int rnum, input int p,
                            input int s, input int d, input int rounds, input int exp_sc);
    int s0, d0;
    setup(mode, s, p, 0, 0, d, 0, ren, rnum);
    s0 = n_scan; d0 = n_done;
    pulse_start();
    repeat (2) @(negedge clk);
    for (int r = 0; r < rounds; r++) begin
      trig_at(1);
      repeat (2) @(negedge clk);
      trig_at(1);
      repeat (p * s + d + 12) @(negedge clk);
    end
    chk("R9 block scans", n_scan - s0, exp_sc);
    chk("R9 single done", n_done - d0, 1);
    chk("R9 idle", int'(acq_busy), 0);
  endtask

  initial begin
    rst_n = 1'b0; tb_tick = 1'b1; sw_start = 1'b0; sw_stop = 1'b0; trig = 1'b0; conv_busy = 1'b0;
    setup(0, 1, 0, 0, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R1 reset scan", int'(scan_start), 0);
    chk("R1 reset busy", int'(acq_busy), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 after release", int'(scan_start | store_en | done | acq_busy), 0);

    for (int s = 1; s <= 3; s++)
      for (int p = 0; p <= 4; p++) run_post(s, p);
    run_post(0, 3);

    for (int s = 1; s <= 3; s++)
      for (int t = 1; t <= 6; t++)
        run_pre(1, s, 2, 0, 0, t, 0, nfires(t, s), nfires(t, s));
    run_pre(1, 2, 0, 0, 0, 5, 0, nfires(5, 2), 0);
    run_pre(1, 2, 3, 1, 0, 3, 9, nfires(9, 2), nfires(9, 2));
    run_pre(2, 2, 2, 0, 3, 4, 0, nfires(4, 2) + 3, nfires(4, 2) + 3);
    run_pre(2, 2, 3, 1, 2, 3, 9, nfires(9, 2) + 2, nfires(9, 2) + 2);
    run_pre(2, 3, 1, 0, 0, 5, 0, nfires(5, 3), nfires(5, 3));

    begin : drain_case
      int s0, d0;
      setup(1, 2, 0, 2, 0, 0, 0, 0, 1);
      s0 = n_scan; d0 = n_done;
      conv_busy = 1'b1;
      pulse_start();
      trig_at(4);
      repeat (6) @(negedge clk);
      chk("R6 busy while draining", int'(acq_busy), 1);
      chk("R6 no done while draining", n_done - d0, 0);
      chk("R6 no scans while draining", n_scan - s0, nfires(4, 2));
      conv_busy = 1'b0;
      repeat (3) @(negedge clk);
      chk("R6 done after drain", n_done - d0, 1);
      chk("R6 idle after drain", int'(acq_busy), 0);
    end

    for (int src = 0; src <= 1; src++)
      for (int d = 0; d <= 3; d++) begin : dly_case
        int s0, lat, expl;
        setup(3, 2, 2, 0, 0, d, src[0], 0, 1);
        s0 = n_scan;
        pulse_start();
        repeat (2) @(negedge clk);
        trig_at(1);
        lat = 0;
        while (!scan_start && lat < 2000) begin @(negedge clk); lat++; end
        expl = (src == 0) ? d + 2 : ((d == 0) ? 2 : (d - 1) * 2 + 3);
        chk("R8 delay latency", lat, expl);
        wait_done();
        chk("R8 delay scans", n_scan - s0, 2);
      end

    run_retrig(0, 1, 3, 3, 2, 0, 4, 9);
    run_retrig(0, 0, 3, 3, 2, 0, 3, 3);
    run_retrig(3, 1, 2, 2, 2, 2, 3, 4);
    run_retrig(0, 1, 0, 2, 1, 0, 2, 2);

    begin : stop_case
      int s0, d0;
      setup(0, 2, 5, 0, 0, 0, 0, 0, 1);
      d0 = n_done;
      pulse_start();
      trig_at(1);
      repeat (4) @(negedge clk);
      sw_stop = 1'b1;
      @(negedge clk) sw_stop = 1'b0;
      chk("R10 stop drops busy", int'(acq_busy), 0);
      s0 = n_scan;
      repeat (20) @(negedge clk);
      chk("R10 no scans after stop", n_scan - s0, 0);
      chk("R10 no done after stop", n_done - d0, 0);
      run_post(2, 3);
    end

    begin : tick_case
      int s0;
      setup(1, 1, 0, 2, 0, 0, 0, 0, 1);
      tb_tick = 1'b0;
      s0 = n_scan;
      pulse_start();
      repeat (20) @(negedge clk);
      chk("R11 no scan without tick", n_scan - s0, 0);
      chk("R11 busy without tick", int'(acq_busy), 1);
      tb_tick = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 scans resume", int'(n_scan - s0 > 0), 1);
      sw_stop = 1'b1;
      @(negedge clk) sw_stop = 1'b0;
      chk("R10 stop from pre", int'(acq_busy), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

endmodule